// File: doc/BRIEF.md
# Masked Signal Trigger Comparator

This block decides, once per clock, whether the signal condition of one trigger state is met. A wide bus carries twelve 128-bit signal groups. A one-hot select picks the group to observe. Four independent bit probes, each addressed by an 8-bit index, take single bits out of that group. Each probe compares its bit with the golden bit at the same index, using one relational operator that all four probes share.

The enabled probe results are merged under an all-must-hit rule or an any-may-hit rule. The merged value is registered and leaves the block as a one-bit match. A sequencer that steps through trigger states would place one instance per state, or reload this instance's configuration ports. The configuration ports are sampled each cycle together with the signal bus.

Top module: `trig_sig_cmp`

## Requirements
- R1: While reset is low, `match_o` is 0, and it stays 0 up to the first rising edge after reset is released, even when the inputs describe a match.
- R2: `match_o` is registered: the value after a rising edge is computed from the inputs present just before that edge, and `match_o` does not change between edges.
- R3: Bit k of `grp_sel` selects group k, which occupies `sig_groups[128*k+127:128*k]`. When several bits are set, the selected groups are ORed bitwise. When no bit is set, the observed group reads as all zeros.
- R4: Operator codes 3'b000 (comparison off) and 3'b100 (reserved) force the next `match_o` to 0, whatever the other inputs are.
- R5: Code 3'b001 makes a probe hit when its signal bit equals its golden bit. Code 3'b101 makes a probe hit when the two bits differ.
- R6: The ordering codes compare the signal bit s with the golden bit g as unsigned 1-bit values: 3'b010 hits when s>g, 3'b011 when s>=g, 3'b110 when s<g, and 3'b111 when s<=g.
- R7: Probe p takes its index from `probe_idx[8*p+7:8*p]`. The low 7 bits of that index pick the bit position within the observed group and within `golden`. Bit 7 of the index is ignored.
- R8: Bit p of `probe_en` enables probe p. When `probe_en` is 0, the next `match_o` is 0 in both merge modes.
- R9: With `any_mode` = 0, the next `match_o` is 1 only when every enabled probe hits.
- R10: With `any_mode` = 1, the next `match_o` is 1 when at least one enabled probe hits. Disabled probes never count toward the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_groups | input | 1536 | Twelve 128-bit signal groups, group k at bits 128k+127:128k |
| grp_sel | input | 12 | One-hot group select |
| probe_idx | input | 32 | Four 8-bit bit indices, probe p at bits 8p+7:8p |
| probe_en | input | 4 | Per-probe enable |
| cmp_op | input | 3 | Relational operator code |
| any_mode | input | 1 | Merge rule: 0 = all enabled probes, 1 = any enabled probe |
| golden | input | 128 | Golden bits; 32-bit word w covers bits 32w+31:32w |
| match_o | output | 1 | Registered match result |

## Verification
Every result of this block is due one rising edge after the inputs that produce it: the group select, probe indices, operator, enables, merge rule, golden bits and signal bus all feed one register. The bench changes inputs only on falling edges. It predicts the result from the inputs it has just applied, and reads `match_o` at the next falling edge, after exactly one rising edge. One directed case also reads the output before that edge, to show the old result holding for the cycle. The reset case holds inputs that describe a match and confirms that the output stays low until the first edge after reset is released.

// File: rtl/trig_cmp_pkg.sv
package trig_cmp_pkg;

    typedef enum logic [2:0] {
        OP_OFF = 3'b000,
        OP_EQ  = 3'b001,
        OP_GT  = 3'b010,
        OP_GE  = 3'b011,
        OP_RSV = 3'b100,
        OP_NE  = 3'b101,
        OP_LT  = 3'b110,
        OP_LE  = 3'b111
    } cmp_op_e;

    // Relation of one observed bit to one golden bit, both unsigned 1-bit.
    function automatic logic rel_hit(cmp_op_e op, logic s, logic g);
        logic r;
        unique case (op)
            OP_EQ:   r = (s == g);
            OP_NE:   r = (s != g);
            OP_GT:   r = (s > g);
            OP_GE:   r = (s >= g);
            OP_LT:   r = (s < g);
            OP_LE:   r = (s <= g);
            OP_OFF:  r = 1'b0;
            OP_RSV:  r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic op_live(cmp_op_e op);
        return !((op == OP_OFF) || (op == OP_RSV));
    endfunction

endpackage

// File: rtl/trig_grp_mux.sv
module trig_grp_mux #(
    parameter int NUM_GROUPS = 12,
    parameter int GROUP_W    = 128
) (
    input  logic [NUM_GROUPS*GROUP_W-1:0] sig_groups,
    input  logic [NUM_GROUPS-1:0]         grp_sel,
    output logic [GROUP_W-1:0]            grp_vec
);
    // AND-OR selector: each select bit gates its own group.
    always_comb begin
        grp_vec = '0;
        for (int k = 0; k < NUM_GROUPS; k++) begin
            if (grp_sel[k]) begin
                grp_vec = grp_vec | sig_groups[k*GROUP_W +: GROUP_W];
            end
        end
    end
endmodule

// File: rtl/trig_bit_probe.sv
module trig_bit_probe #(
    parameter int GROUP_W = 128,
    parameter int IDX_W   = 8
) (
    input  logic [GROUP_W-1:0]          grp_vec,
    input  logic [GROUP_W-1:0]          golden,
    input  logic [IDX_W-1:0]            idx,
    input  trig_cmp_pkg::cmp_op_e       op,
    output logic                        hit
);
    localparam int SEL_W = (GROUP_W > 1) ? $clog2(GROUP_W) : 1;

    logic [SEL_W-1:0] bit_pos;
    logic             obs_bit;
    logic             gold_bit;

    assign bit_pos = idx[SEL_W-1:0];

    generate
        if (IDX_W > SEL_W) begin : g_idx_hi
            logic unused_idx_hi;
            assign unused_idx_hi = ^idx[IDX_W-1:SEL_W];
        end
    endgenerate

    always_comb begin
        obs_bit  = grp_vec[bit_pos];
        gold_bit = golden[bit_pos];
        hit      = trig_cmp_pkg::rel_hit(op, obs_bit, gold_bit);
    end
endmodule

// File: rtl/trig_combiner.sv
module trig_combiner #(
    parameter int NUM_PROBES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PROBES-1:0] hit,
    input  logic [NUM_PROBES-1:0] en,
    input  logic                  any_mode,
    input  logic                  op_on,
    output logic                  match_q
);
    logic [NUM_PROBES-1:0] en_hits;
    logic                  all_hit;
    logic                  some_hit;
    logic                  match_d;

    always_comb begin
        en_hits  = hit & en;
        all_hit  = (en_hits == en);
        some_hit = |en_hits;
        unique case (any_mode)
            1'b0: match_d = op_on && (|en) && all_hit;
            1'b1: match_d = op_on && (|en) && some_hit;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
        end else begin
            match_q <= match_d;
        end
    end

    assert_no_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |=> !match_q);

    assert_all_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_mode && op_on && (en != '0) && ((hit & en) == en)) |=> match_q);

    assert_any_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (any_mode && ((hit & en) == '0)) |=> !match_q);
endmodule

// File: rtl/trig_sig_cmp.sv
module trig_sig_cmp #(
    parameter int NUM_GROUPS = 12,
    parameter int GROUP_W    = 128,
    parameter int NUM_PROBES = 4,
    parameter int IDX_W      = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_GROUPS*GROUP_W-1:0] sig_groups,
    input  logic [NUM_GROUPS-1:0]         grp_sel,
    input  logic [NUM_PROBES*IDX_W-1:0]   probe_idx,
    input  logic [NUM_PROBES-1:0]         probe_en,
    input  logic [2:0]                    cmp_op,
    input  logic                          any_mode,
    input  logic [GROUP_W-1:0]            golden,
    output logic                          match_o
);
    import trig_cmp_pkg::*;

    cmp_op_e               op;
    logic [GROUP_W-1:0]    grp_vec;
    logic [NUM_PROBES-1:0] probe_hit;
    logic                  op_on;

    assign op    = cmp_op_e'(cmp_op);
    assign op_on = op_live(op);

    trig_grp_mux #(
        .NUM_GROUPS (NUM_GROUPS),
        .GROUP_W    (GROUP_W)
    ) u_mux (
        .sig_groups (sig_groups),
        .grp_sel    (grp_sel),
        .grp_vec    (grp_vec)
    );

    generate
        for (genvar p = 0; p < NUM_PROBES; p++) begin : g_probe
            trig_bit_probe #(
                .GROUP_W (GROUP_W),
                .IDX_W   (IDX_W)
            ) u_probe (
                .grp_vec (grp_vec),
                .golden  (golden),
                .idx     (probe_idx[p*IDX_W +: IDX_W]),
                .op      (op),
                .hit     (probe_hit[p])
            );
        end
    endgenerate

    trig_combiner #(
        .NUM_PROBES (NUM_PROBES)
    ) u_comb (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (probe_hit),
        .en       (probe_en),
        .any_mode (any_mode),
        .op_on    (op_on),
        .match_q  (match_o)
    );

    assert_op_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp_op == 3'b000) || (cmp_op == 3'b100)) |=> !match_o);

    assert_no_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_sel == '0) |-> (grp_vec == '0));
endmodule

// File: tb/sim_trig_sig_cmp.sv
module sim_trig_sig_cmp;
    localparam int NG = 12;
    localparam int GW = 128;
    localparam int NP = 4;
    localparam int IW = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NG*GW-1:0]  sig_groups;
    logic [NG-1:0]     grp_sel;
    logic [NP*IW-1:0]  probe_idx;
    logic [NP-1:0]     probe_en;
    logic [2:0]        cmp_op;
    logic              any_mode;
    logic [GW-1:0]     golden;
    logic              match_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    trig_sig_cmp u0 (
        .clk(clk), .rst_n(rst_n), .sig_groups(sig_groups), .grp_sel(grp_sel),
        .probe_idx(probe_idx), .probe_en(probe_en), .cmp_op(cmp_op),
        .any_mode(any_mode), .golden(golden), .match_o(match_o)
    );

    function automatic logic model(logic [NG*GW-1:0] grp, logic [NG-1:0] sel,
                                   logic [NP*IW-1:0] idx, logic [NP-1:0] en,
                                   logic [2:0] op, logic anym, logic [GW-1:0] gold);
        logic [GW-1:0] v;
        logic          all_ok;
        logic          any_ok;
        v = '0;
        for (int k = 0; k < NG; k++) if (sel[k]) v = v | grp[k*GW +: GW];
        all_ok = 1'b1;
        any_ok = 1'b0;
        for (int p = 0; p < NP; p++) begin
            logic [6:0] b;
            logic s, g, h;
            b = idx[p*IW +: 7];
            s = v[b];
            g = gold[b];
            case (op)
                3'b001: h = (s == g);
                3'b101: h = (s != g);
                3'b010: h = s & ~g;
                3'b011: h = s | ~g;
                3'b110: h = ~s & g;
                3'b111: h = ~s | g;
                default: h = 1'b0;
            endcase
            if (en[p]) begin
                if (h) any_ok = 1'b1;
                else   all_ok = 1'b0;
            end
        end
        if (en == '0 || op == 3'b000 || op == 3'b100) return 1'b0;
        return anym ? any_ok : all_ok;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: match_o actual %b expected %b", tag, act, exp);
        end
    endtask

    // Inputs are already applied at a falling edge; one rising edge, then sample.
    task automatic step(string tag);
        logic e;
        e = model(sig_groups, grp_sel, probe_idx, probe_en, cmp_op, any_mode, golden);
        @(negedge clk);
        check(tag, match_o, e);
    endtask

    task automatic step_fixed(string tag, logic exp);
        @(negedge clk);
        check(tag, match_o, exp);
    endtask

    task automatic base_cfg();
        sig_groups = '0;
        golden     = '1;
        grp_sel    = 12'h001;
        probe_idx  = '0;
        probe_en   = 4'b0001;
        cmp_op     = 3'b001;
        any_mode   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not end, actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_v;
        seed_v = $urandom(32'h1bad5eed);
        rst_n = 1'b0;
        base_cfg();
        sig_groups[5] = 1'b1;   // bit 5 of group 0, probe 0 index 5 would match
        probe_idx[7:0] = 8'd5;
        repeat (3) @(negedge clk);
        check("R1 in reset", match_o, 1'b0);
        rst_n = 1'b1;
        #1 check("R1 after release, before edge", match_o, 1'b0);
        step_fixed("R1/R2 first edge", 1'b1);

        // R7: bit 7 of the index is ignored
        probe_idx[7:0] = 8'h85;
        step_fixed("R7 index 0x85 -> bit 5", 1'b1);
        probe_idx[7:0] = 8'h86;
        step_fixed("R7 index 0x86 -> bit 6", 1'b0);

        // R2: output holds between edges
        probe_idx[7:0] = 8'd5;
        #1 check("R2 hold before edge", match_o, 1'b0);
        step_fixed("R2 update after one edge", 1'b1);

        // R3: group selection
        base_cfg();
        sig_groups[11*GW + 9] = 1'b1;
        probe_idx[7:0] = 8'd9;
        grp_sel = 12'h800;
        step_fixed("R3 group 11", 1'b1);
        grp_sel = 12'h400;
        step_fixed("R3 group 10", 1'b0);
        grp_sel = 12'hC00;
        step_fixed("R3 multi-hot OR", 1'b1);
        grp_sel = 12'h000; golden = '0;
        step_fixed("R3 no group reads zero", 1'b1);

        // R4: disabled and reserved codes
        cmp_op = 3'b000;
        step_fixed("R4 code 000", 1'b0);
        cmp_op = 3'b100;
        step_fixed("R4 code 100", 1'b0);

        // R5 / R6: operators on s=1 (group 11 bit 9)
        base_cfg();
        sig_groups[11*GW + 9] = 1'b1;
        probe_idx[7:0] = 8'd9;
        grp_sel = 12'h800;
        cmp_op = 3'b101;
        step_fixed("R5 NE s=1 g=1", 1'b0);
        golden = '0;
        step_fixed("R5 NE s=1 g=0", 1'b1);
        cmp_op = 3'b010;
        step_fixed("R6 GT s=1 g=0", 1'b1);
        cmp_op = 3'b110;
        step_fixed("R6 LT s=1 g=0", 1'b0);
        probe_idx[7:0] = 8'd8;   // s=0
        cmp_op = 3'b111;
        step_fixed("R6 LE s=0 g=0", 1'b1);
        golden = '1;
        cmp_op = 3'b011;
        step_fixed("R6 GE s=0 g=1", 1'b0);

        // R8, R9, R10: enables and merge rule
        base_cfg();
        sig_groups[3] = 1'b1;
        probe_idx = {8'd0, 8'd0, 8'd4, 8'd3};   // p0 hits, p1 misses
        probe_en = 4'b0000; any_mode = 1'b1;
        step_fixed("R8 no enables", 1'b0);
        probe_en = 4'b0011; any_mode = 1'b0;
        step_fixed("R9 all mode one miss", 1'b0);
        any_mode = 1'b1;
        step_fixed("R10 any mode one hit", 1'b1);
        probe_en = 4'b0010;
        step_fixed("R10 disabled hit ignored", 1'b0);
        probe_en = 4'b0001; any_mode = 1'b0;
        step_fixed("R9 all enabled hit", 1'b1);

        // Random stimulus against the bench model
        for (int n = 0; n < 400; n++) begin
            for (int w = 0; w < NG*GW/32; w++) sig_groups[w*32 +: 32] = $urandom;
            for (int w = 0; w < GW/32; w++) golden[w*32 +: 32] = $urandom;
            grp_sel   = ($urandom % 5 == 0) ? 12'($urandom) : 12'(1) << ($urandom % NG);
            probe_idx = $urandom;
            probe_en  = 4'($urandom);
            cmp_op    = 3'($urandom);
            any_mode  = 1'($urandom);
            step("R3-R10 random mix, tags R5 R6 R9 R10");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule